// File: doc/BRIEF.md
# Tone Detect Guard-Time Qualifier

This block takes the raw flag of a dual-tone alert detector and turns it into a steering output that is qualified by guard times. It is a counter-based, fully digital stand-in for the resistor-capacitor guard network that usually sits beside such a detector. The raw flag must stay high without a break for a programmable tone-present time before the qualified output rises. Once the output is high, the raw flag must stay low without a break for a programmable tone-absent time before the output falls. Shorter bursts are rejected and shorter dropouts are bridged. The two times are independent, so the present time can be longer than the absent time. One alerting profile needs this: at least 20 ms present and 15 to 17 ms absent.

The raw flag first passes through a two-flop synchronizer. Both guard times are given in clock ticks. The absent time is captured when the output asserts, so later writes to it cannot shorten a release that is already under way. A disable input keeps the qualified output low while the synchronized raw flag is still shown on an early output. A power-down input forces both outputs low and returns the timer to idle. An interrupt request is active whenever the qualified output is high.

Top module: `tone_guard_qualifier`

## Requirements
- R1: After the raw input rises and stays high, the qualified output rises exactly P+2 clock edges later. P is `present_ticks`, and the 2 extra edges come from the synchronizer.
- R2: If the raw input is high for fewer than P consecutive sampled cycles, the qualified output never rises. Any low sample restarts the present interval from zero.
- R3: While qualified, if the raw input falls and stays low, the qualified output falls exactly A+2 clock edges later. A is the absent time.
- R4: While qualified, a raw low pulse shorter than A sampled cycles is masked: the output stays high, and any high sample restarts the absent interval.
- R5: A is taken from `absent_ticks` on the clock edge where the qualified output asserts. Changes to `absent_ticks` made while qualified have no effect on that release.
- R6: A value of 0 in `present_ticks` or `absent_ticks` behaves as 1.
- R7: While `detect_off` is 1, `qualified` is 0 and the timer is held idle, but `early_flag` still follows the synchronized raw input. After `detect_off` goes to 0 with raw high, `qualified` rises P edges later.
- R8: While `power_down` is 1, `qualified` and `early_flag` are 0, and the timer and synchronizer are cleared. After release, a full qualification (R1) is needed.
- R9: `irq` is high exactly when `qualified` is high.
- R10: After reset, `qualified`, `early_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_detect | input | 1 | Raw dual-tone detect flag, asynchronous |
| detect_off | input | 1 | Detector disable; holds the qualified output low |
| power_down | input | 1 | Forces outputs low and clears all state |
| present_ticks | input | CNT_W | Tone-present guard time in clock ticks |
| absent_ticks | input | CNT_W | Tone-absent guard time in clock ticks |
| early_flag | output | 1 | Synchronized raw flag (unqualified) |
| qualified | output | 1 | Guard-time-qualified detect flag |
| irq | output | 1 | Interrupt request, active while qualified |

## Verification
The bench keeps the default 20-bit counters but drives short guard times: a present time of 12 ticks and an absent time of 7 ticks for most scenarios, plus 0 and 3 for the corner cases. With these values, bursts and dropouts that stop exactly one tick short of a guard time can be checked in a few dozen cycles. They also make the unequal present and absent times clearly different. Changing the absent time while the output is qualified shows whether the latched value or the live value sets the release edge.

// File: rtl/tone_guard_qualifier.sv
module tone_guard_qualifier #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_detect,
  input  logic             detect_off,
  input  logic             power_down,
  input  logic [CNT_W-1:0] present_ticks,
  input  logic [CNT_W-1:0] absent_ticks,
  output logic             early_flag,
  output logic             qualified,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             sync1, sync2, qual_q;
  logic [CNT_W-1:0] cnt, absent_lat;

  wire [CNT_W-1:0] p_lim  = (present_ticks == '0) ? ONE : present_ticks;
  wire [CNT_W-1:0] a_eff  = (absent_ticks  == '0) ? ONE : absent_ticks;
  wire [CNT_W-1:0] cnt_nx = cnt + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0; sync2 <= 1'b0; qual_q <= 1'b0;
      cnt <= '0; absent_lat <= ONE;
    end else if (power_down) begin
      sync1 <= 1'b0; sync2 <= 1'b0; qual_q <= 1'b0;
      cnt <= '0;
    end else begin
      sync1 <= raw_detect;
      sync2 <= sync1;
      if (detect_off) begin
        qual_q <= 1'b0;
        cnt    <= '0;
      end else if (!qual_q) begin
        if (!sync2) cnt <= '0;
        else if (cnt_nx >= p_lim) begin
          qual_q     <= 1'b1;
          cnt        <= '0;
          absent_lat <= a_eff;
        end else cnt <= cnt_nx;
      end else begin
        if (sync2) cnt <= '0;
        else if (cnt_nx >= absent_lat) begin
          qual_q <= 1'b0;
          cnt    <= '0;
        end else cnt <= cnt_nx;
      end
    end
  end

  assign early_flag = sync2 & ~power_down;
  assign qualified  = qual_q & ~detect_off & ~power_down;
  assign irq        = qualified;

  assert_rise_needs_raw_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> $past(sync2));
  assert_present_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_q |-> (cnt < p_lim));
  assert_fall_needs_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(qual_q) && !$past(power_down) && !$past(detect_off)) |-> !$past(sync2));
  assert_absent_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    qual_q |-> (cnt < absent_lat));
  assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(detect_off) |-> (!qual_q && cnt == '0));
  assert_powerdown_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(power_down) |-> (!qual_q && !sync2 && cnt == '0));
endmodule

// File: tb/sim_tone_guard_qualifier.sv
module sim_tone_guard_qualifier;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0, raw = 1'b0, doff = 1'b0, pd = 1'b0;
  logic [W-1:0] pt = W'(12), at = W'(7);
  logic early, qual, irq;
  int checks = 0, errors = 0, cycles = 0;

  tone_guard_qualifier #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_detect(raw), .detect_off(doff),
    .power_down(pd), .present_ticks(pt), .absent_ticks(at),
    .early_flag(early), .qualified(qual), .irq(irq));

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_all();
    @(negedge clk); raw = 1'b0; doff = 1'b0; pd = 1'b0;
    pt = W'(12); at = W'(7);
    edges(30);
  endtask

  task automatic qualify_now();
    raw = 1'b1; edges(16);
  endtask

  task automatic t_reset();
    edges(2);
    chk("R10 qualified", qual, 1'b0);
    chk("R10 early", early, 1'b0);
    chk("R10 irq", irq, 1'b0);
    rst_n = 1'b1; edges(2);
  endtask

  task automatic t_rise();
    idle_all();
    raw = 1'b1;
    edges(13);
    chk("R1 before P+2", qual, 1'b0);
    chk("R9 irq low", irq, 1'b0);
    edges(1);
    chk("R1 at P+2", qual, 1'b1);
    chk("R9 irq high", irq, 1'b1);
  endtask

  task automatic t_burst();
    idle_all();
    raw = 1'b1; edges(11);
    raw = 1'b0; edges(20);
    chk("R2 short burst", qual, 1'b0);
    raw = 1'b1; edges(6);
    raw = 1'b0; edges(1);
    raw = 1'b1; edges(13);
    chk("R2 restart after gap", qual, 1'b0);
    edges(1);
    chk("R2 full after restart", qual, 1'b1);
  endtask

  task automatic t_release();
    idle_all(); qualify_now();
    raw = 1'b0;
    edges(8);
    chk("R3 before A+2", qual, 1'b1);
    edges(1);
    chk("R3 at A+2", qual, 1'b0);
  endtask

  task automatic t_dropout();
    idle_all(); qualify_now();
    raw = 1'b0; edges(6);
    raw = 1'b1; edges(20);
    chk("R4 dropout masked", qual, 1'b1);
    raw = 1'b0; edges(5);
    raw = 1'b1; edges(1);
    raw = 1'b0; edges(8);
    chk("R4 restart of absent", qual, 1'b1);
    edges(1);
    chk("R4 release after restart", qual, 1'b0);
  endtask

  task automatic t_latch();
    idle_all(); qualify_now();
    at = W'(3);
    raw = 1'b0;
    edges(8);
    chk("R5 latched absent holds", qual, 1'b1);
    edges(1);
    chk("R5 latched absent release", qual, 1'b0);
  endtask

  task automatic t_zero();
    idle_all();
    pt = '0; at = '0;
    raw = 1'b1; edges(2);
    chk("R6 zero present before", qual, 1'b0);
    edges(1);
    chk("R6 zero present as one", qual, 1'b1);
    raw = 1'b0; edges(2);
    chk("R6 zero absent before", qual, 1'b1);
    edges(1);
    chk("R6 zero absent as one", qual, 1'b0);
  endtask

  task automatic t_disable();
    idle_all();
    doff = 1'b1; raw = 1'b1; edges(30);
    chk("R7 held low", qual, 1'b0);
    chk("R7 early follows", early, 1'b1);
    doff = 1'b0; edges(11);
    chk("R7 before P", qual, 1'b0);
    edges(1);
    chk("R7 at P", qual, 1'b1);
    doff = 1'b1; #1;
    chk("R7 immediate low", qual, 1'b0);
  endtask

  task automatic t_powerdown();
    idle_all(); qualify_now();
    pd = 1'b1; #1;
    chk("R8 qualified low", qual, 1'b0);
    chk("R8 early low", early, 1'b0);
    edges(5);
    chk("R8 irq low", irq, 1'b0);
    pd = 1'b0;
    edges(13);
    chk("R8 requalify before", qual, 1'b0);
    edges(1);
    chk("R8 requalify full", qual, 1'b1);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_burst();
    t_release();
    t_dropout();
    t_latch();
    t_zero();
    t_disable();
    t_powerdown();
    finish_run();
  end
endmodule